// File: doc/BRIEF.md
# Video 4:2:2 Output Formatter

This block takes one full-bandwidth pixel per clock as three components (luma, blue-difference chroma, red-difference chroma) and a horizontal sync marker. It produces a video stream on three data buses and a sync output. In 4:2:2 mode, one bus carries luma for every pixel. A second bus carries chroma that alternates between blue-difference and red-difference on successive pixels. In 4:4:4 mode, all three components pass through unchanged.

Chroma is decimated by selection only, with no filtering. The pixel in the even slot of each pair gives both chroma samples. Its blue-difference value goes out in its own slot. Its red-difference value is held and goes out in the following slot. The pair phase is forced back to blue-difference on every leading edge of the sync marker, so each line starts on a known chroma component.

The data path has a fixed latency of eight register stages. The sync path is shorter, at two stages. The leading edge of the sync output therefore comes six clocks (an even count) ahead of the pixel that was sampled with the sync leading edge. A valid flag travels through the data pipeline and marks when that pipeline has filled after reset.

Top module: `vid422_formatter`

## Requirements
- R1: The luma value sampled at rising edge n is on `out_y` after edge n+7 and is held until edge n+8, giving eight register stages, in both modes.
- R2: When `fmt_422` was 0 at the sampling edge, `out_c` carries that pixel's blue-difference value and `out_cr` carries its red-difference value, both with the R1 latency.
- R3: When `fmt_422` was 1, the chroma phase alternates on every pixel. A phase-0 pixel puts its own blue-difference value on `out_c`. A phase-1 pixel puts the red-difference value of the pixel just before it on `out_c`. `out_cr` is 0.
- R4: A pixel sampled with `hs_in` = 1 has phase 0 if the previous pixel was sampled with `hs_in` = 0, or if it is the first pixel after reset. The first pixel after reset has phase 0 even when `hs_in` is 0.
- R5: `hs_out` after edge n+1 equals `hs_in` sampled at edge n, giving two register stages.
- R6: A rising edge on `hs_out` comes exactly 6 clocks before the pixel that started the line appears on the data outputs. In 4:2:2 mode, that pixel's slot on `out_c` holds blue-difference chroma.
- R7: `out_valid` is 0 from reset release until edge 8 after it. The first edge after release counts as edge 1. From edge 8 on, `out_valid` is 1 and stays 1.
- R8: While `rst_n` is low, all outputs are 0, without waiting for a clock edge.
- R9: `fmt_422` is sampled per pixel and travels with that pixel, so a mode change affects only the pixels sampled after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_422 | input | 1 | 1 selects 4:2:2 formatting, 0 selects 4:4:4 pass-through |
| pix_y | input | W | Luma of the input pixel |
| pix_cb | input | W | Blue-difference chroma of the input pixel |
| pix_cr | input | W | Red-difference chroma of the input pixel |
| hs_in | input | 1 | Horizontal sync marker, active high |
| out_y | output | W | Delayed luma |
| out_c | output | W | Alternating chroma (4:2:2) or blue-difference chroma (4:4:4) |
| out_cr | output | W | Red-difference chroma (4:4:4), zero in 4:2:2 |
| out_valid | output | 1 | Data pipeline holds real pixels |
| hs_out | output | 1 | Sync marker aligned to the output timing |

## Verification
The assertions assume that every clock carries a pixel and that `hs_in` and `fmt_422` are synchronous to `clk`. They also assume that reset is held long enough to clear all stages. The latency properties compare against input values from eight or two cycles earlier, so they rely on `out_valid` and the stage-two valid bit to exclude cycles that reach back into reset.

The stimulus drives every input half a cycle away from the active edge. It releases reset on a clean boundary and holds the random sync marker high for one to three pixels per line. Line lengths are random and include odd values, which moves the sync leading edge onto both chroma phases. A late section switches `fmt_422` randomly on individual pixels.

// File: rtl/vid422_pkg.sv
package vid422_pkg;

    // Chroma pair phase carried along with each pixel
    typedef enum logic {
        PH_CB = 1'b0,
        PH_CR = 1'b1
    } chroma_ph_e;

    // Total register stages on the data path and on the sync path
    localparam int DATA_STAGES = 8;
    localparam int SYNC_STAGES = 2;
    // Stages spent before the generic delay line (phase tracker + selector)
    localparam int FRONT_STAGES = 2;

endpackage

// File: rtl/vid_phase_track.sv
module vid_phase_track
    import vid422_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fmt_422,
    input  logic [W-1:0] pix_y,
    input  logic [W-1:0] pix_cb,
    input  logic [W-1:0] pix_cr,
    input  logic         hs_in,
    output logic         s1_vld,
    output logic         s1_hs,
    output logic         s1_m422,
    output chroma_ph_e   s1_ph,
    output logic [W-1:0] s1_y,
    output logic [W-1:0] s1_cb,
    output logic [W-1:0] s1_cr
);

    typedef struct packed {
        logic       vld;
        logic       hs;
        logic       m422;
        chroma_ph_e ph;
        logic [W-1:0] y;
        logic [W-1:0] cb;
        logic [W-1:0] cr;
    } trk_t;

    trk_t st_d, st_q;
    logic lead;

    always_comb begin
        st_d = st_q;
        // leading edge: sync high now, low (or reset) for the previous pixel
        lead     = hs_in & ~st_q.hs;
        st_d.vld = 1'b1;
        st_d.hs  = hs_in;
        st_d.m422 = fmt_422;
        st_d.y   = pix_y;
        st_d.cb  = pix_cb;
        st_d.cr  = pix_cr;
        if (lead) begin
            st_d.ph = PH_CB;
        end else if (st_q.ph == PH_CB) begin
            st_d.ph = PH_CR;
        end else begin
            st_d.ph = PH_CB;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            // preset so the first pixel after reset lands on blue-difference
            st_q.ph <= PH_CR;
        end else begin
            st_q <= st_d;
        end
    end

    assign s1_vld  = st_q.vld;
    assign s1_hs   = st_q.hs;
    assign s1_m422 = st_q.m422;
    assign s1_ph   = st_q.ph;
    assign s1_y    = st_q.y;
    assign s1_cb   = st_q.cb;
    assign s1_cr   = st_q.cr;

    // R4: a line start always opens on blue-difference
    a_r4_lead_is_cb: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && st_q.hs && !$past(st_q.hs)) |-> (st_q.ph == PH_CB));

    // R3: without a line start the phase flips on each pixel
    a_r3_phase_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld && $past(st_q.vld) && !(st_q.hs && !$past(st_q.hs)))
        |-> (st_q.ph != $past(st_q.ph)));

endmodule

// File: rtl/vid_chroma_sel.sv
module vid_chroma_sel
    import vid422_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic         in_hs,
    input  logic         in_m422,
    input  chroma_ph_e   in_ph,
    input  logic [W-1:0] in_y,
    input  logic [W-1:0] in_cb,
    input  logic [W-1:0] in_cr,
    output logic         s2_vld,
    output logic         s2_hs,
    output logic [W-1:0] s2_y,
    output logic [W-1:0] s2_c,
    output logic [W-1:0] s2_cr
);

    typedef struct packed {
        logic         vld;
        logic         hs;
        logic [W-1:0] y;
        logic [W-1:0] c;
        logic [W-1:0] cr;
        logic [W-1:0] hold;
    } sel_t;

    sel_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        st_d.hs  = in_hs;
        st_d.y   = in_y;
        if (in_m422) begin
            st_d.c  = (in_ph == PH_CB) ? in_cb : st_q.hold;
            st_d.cr = '0;
        end else begin
            st_d.c  = in_cb;
            st_d.cr = in_cr;
        end
        // red-difference of the even pixel waits one slot
        if (in_vld && in_ph == PH_CB) begin
            st_d.hold = in_cr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign s2_vld = st_q.vld;
    assign s2_hs  = st_q.hs;
    assign s2_y   = st_q.y;
    assign s2_c   = st_q.c;
    assign s2_cr  = st_q.cr;

    // R3: the held red-difference comes from the latest blue-phase pixel
    a_r3_hold_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_ph == PH_CB) |=> (st_q.hold == $past(in_cr)));

    // R3: a blue-phase slot in 4:2:2 shows that pixel's own blue-difference
    a_r3_cb_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_m422 && in_ph == PH_CB) |=> (s2_c == $past(in_cb) && s2_cr == '0));

endmodule

// File: rtl/vid_delay_line.sv
module vid_delay_line #(
    parameter int WD    = 8,
    parameter int DEPTH = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [WD-1:0] din,
    output logic [WD-1:0] dout
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign dout = din;
        end else begin : g_pipe
            logic [DEPTH-1:0][WD-1:0] pipe_d, pipe_q;

            always_comb begin
                pipe_d[0] = din;
                for (int i = 1; i < DEPTH; i++) begin
                    pipe_d[i] = pipe_q[i-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe_q <= '0;
                end else begin
                    pipe_q <= pipe_d;
                end
            end

            assign dout = pipe_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/vid422_formatter.sv
module vid422_formatter
    import vid422_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fmt_422,
    input  logic [W-1:0] pix_y,
    input  logic [W-1:0] pix_cb,
    input  logic [W-1:0] pix_cr,
    input  logic         hs_in,
    output logic [W-1:0] out_y,
    output logic [W-1:0] out_c,
    output logic [W-1:0] out_cr,
    output logic         out_valid,
    output logic         hs_out
);

    localparam int TAIL  = DATA_STAGES - FRONT_STAGES;
    localparam int BUS_W = 3 * W + 1;

    logic         s1_vld, s1_hs, s1_m422;
    chroma_ph_e   s1_ph;
    logic [W-1:0] s1_y, s1_cb, s1_cr;
    logic         s2_vld, s2_hs;
    logic [W-1:0] s2_y, s2_c, s2_cr;
    logic [BUS_W-1:0] tail_in, tail_out;

    vid_phase_track #(.W(W)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .fmt_422 (fmt_422),
        .pix_y   (pix_y),
        .pix_cb  (pix_cb),
        .pix_cr  (pix_cr),
        .hs_in   (hs_in),
        .s1_vld  (s1_vld),
        .s1_hs   (s1_hs),
        .s1_m422 (s1_m422),
        .s1_ph   (s1_ph),
        .s1_y    (s1_y),
        .s1_cb   (s1_cb),
        .s1_cr   (s1_cr)
    );

    vid_chroma_sel #(.W(W)) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (s1_vld),
        .in_hs   (s1_hs),
        .in_m422 (s1_m422),
        .in_ph   (s1_ph),
        .in_y    (s1_y),
        .in_cb   (s1_cb),
        .in_cr   (s1_cr),
        .s2_vld  (s2_vld),
        .s2_hs   (s2_hs),
        .s2_y    (s2_y),
        .s2_c    (s2_c),
        .s2_cr   (s2_cr)
    );

    assign tail_in = {s2_vld, s2_y, s2_c, s2_cr};

    vid_delay_line #(.WD(BUS_W), .DEPTH(TAIL)) u_tail (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (tail_in),
        .dout  (tail_out)
    );

    assign out_valid = tail_out[BUS_W-1];
    assign out_y     = tail_out[3*W-1 -: W];
    assign out_c     = tail_out[2*W-1 -: W];
    assign out_cr    = tail_out[W-1:0];
    // sync leaves after the selector stage: SYNC_STAGES registers
    assign hs_out    = s2_hs;

    // R1: luma latency of eight stages
    a_r1_luma_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_y == $past(pix_y, 8)));

    // R2: pass-through keeps both chroma components
    a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(fmt_422, 8))
        |-> (out_c == $past(pix_cb, 8) && out_cr == $past(pix_cr, 8)));

    // R5: sync path of two stages
    a_r5_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
        s2_vld |-> (hs_out == $past(hs_in, 2)));

    // R7: once filled the pipeline stays valid
    a_r7_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(out_valid) |-> out_valid);

endmodule

// File: tb/vid422_formatter_tb.sv
`timescale 1ns/1ps
module vid422_formatter_tb;

    localparam int W = 10;
    localparam int N = 3000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fmt_422 = 1'b1;
    logic [W-1:0] pix_y = '0, pix_cb = '0, pix_cr = '0;
    logic         hs_in = 1'b0;
    logic [W-1:0] out_y, out_c, out_cr;
    logic         out_valid, hs_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // per-cycle records, computed from the requirements
    logic [W-1:0] rec_y [N];
    logic [W-1:0] rec_c [N];
    logic [W-1:0] rec_cr[N];
    logic [W-1:0] rec_cb[N];
    logic         rec_hs[N];
    logic         rec_lead[N];
    logic         rec_m422[N];
    logic         rst_at[N];
    logic         hs_obs[N];

    always #10 clk = ~clk;

    vid422_formatter #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .fmt_422(fmt_422),
        .pix_y(pix_y), .pix_cb(pix_cb), .pix_cr(pix_cr), .hs_in(hs_in),
        .out_y(out_y), .out_c(out_c), .out_cr(out_cr),
        .out_valid(out_valid), .hs_out(hs_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // expected 4:2:2 chroma slot (R3)
    function automatic logic [W-1:0] sel_c(input logic m422, input logic ph,
                                           input logic [W-1:0] cb,
                                           input logic [W-1:0] hold);
        if (!m422) return cb;
        return (ph == 1'b0) ? cb : hold;
    endfunction

    initial begin
        int seed;
        int rel;
        int line_left;
        int hs_left;
        logic m_hs_last, m_ph;
        logic [W-1:0] m_hold;
        seed = $urandom(32'h5eed_4221);
        rel = 0; line_left = 0; hs_left = 0;
        m_hs_last = 0; m_ph = 1; m_hold = '0;
        for (int k = 0; k < N; k++) begin
            logic r, h, md, ld, ph;
            logic [W-1:0] y, cb, cr;
            @(negedge clk);
            hs_obs[k] = hs_out;
            // ---------------- checks for state after edge k-1
            if (k == 0 || !rst_at[k-1]) begin
                chk(out_y == 0 && out_c == 0 && out_cr == 0, "R8 reset data", out_y, 0);
                chk(out_valid == 0 && hs_out == 0, "R8 reset flags", {out_valid, hs_out}, 0);
            end else begin
                int j;
                int j2;
                j = k - 8;
                j2 = k - 2;
                if (j >= rel) begin
                    chk(out_valid == 1, "R7 valid high", out_valid, 1);
                    chk(out_y == rec_y[j], "R1 luma", out_y, rec_y[j]);
                    chk(out_c == rec_c[j], rec_m422[j] ? "R3 chroma slot" : "R2 cb pass",
                        out_c, rec_c[j]);
                    chk(out_cr == rec_cr[j], rec_m422[j] ? "R3 cr zero" : "R2 cr pass",
                        out_cr, rec_cr[j]);
                    if (rec_lead[j]) begin
                        chk(hs_obs[k-6] == 1, "R6 sync 6 ahead", hs_obs[k-6], 1);
                        if (j > rel)
                            chk(hs_obs[k-7] == 0, "R6 sync edge", hs_obs[k-7], 0);
                        if (rec_m422[j])
                            chk(out_c == rec_cb[j], "R6 R4 first is cb", out_c, rec_cb[j]);
                    end
                end else begin
                    chk(out_valid == 0, "R7 valid low while filling", out_valid, 0);
                    chk(out_y == 0, "R7 fill data", out_y, 0);
                end
                if (j2 >= rel)
                    chk(hs_out == rec_hs[j2], "R5 sync latency", hs_out, rec_hs[j2]);
                else
                    chk(hs_out == 0, "R5 sync fill", hs_out, 0);
            end
            // ---------------- stimulus for edge k
            r = !((k < 4) || (k >= 1500 && k < 1504));
            if (k < 800)       md = 1'b1;
            else if (k < 1100) md = 1'b0;
            else if (k < 2000) md = 1'b1;
            else if (k < 2100) md = 1'($urandom_range(0, 1));   // R9
            else               md = 1'b1;
            // sync: directed high on first pixel after each reset, else random lines
            if (k == 4 || k == 1504) begin
                h = 1'b1; hs_left = 1; line_left = 9;
            end else if (k >= 300 && k < 340) begin
                h = 1'b0;                                       // long line, free-run phase
            end else begin
                if (line_left == 0) begin
                    line_left = $urandom_range(4, 23);
                    hs_left = $urandom_range(1, 3);
                end
                h = (hs_left > 0);
                if (hs_left > 0) hs_left--;
                line_left--;
            end
            y  = W'($urandom);
            cb = W'($urandom);
            cr = W'($urandom);
            if (k == 600) begin y = '1; cb = '1; cr = '0; end
            rst_n = r; fmt_422 = md; hs_in = h;
            pix_y = y; pix_cb = cb; pix_cr = cr;
            rst_at[k] = r;
            // ---------------- reference model
            if (!r) begin
                m_hs_last = 0; m_ph = 1; m_hold = '0;
                rec_lead[k] = 0;
            end else begin
                if (k > 0 && !rst_at[k-1]) rel = k;
                ld = h & ~m_hs_last;
                ph = ld ? 1'b0 : ~m_ph;
                rec_y[k]    = y;
                rec_cb[k]   = cb;
                rec_hs[k]   = h;
                rec_lead[k] = ld;
                rec_m422[k] = md;
                rec_c[k]    = sel_c(md, ph, cb, m_hold);
                rec_cr[k]   = md ? '0 : cr;
                if (ph == 1'b0) m_hold = cr;
                m_ph = ph;
                m_hs_last = h;
            end
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=0 exp=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule